// File: doc/BRIEF.md
# Prioritized Event Flag Controller

The controller takes eight asynchronous single-bit event sources and turns each rising edge into a latched flag. Each source has its own enable bit. Software clears a pending flag by writing a one to its bit. The flags form two groups. Sources 7 down to 4 are the urgent group and drive the `evtHigh` request line. Sources 3 down to 0 are the routine group and drive `evtLow`. Each line is the OR of the flags in its group.

To help service code, two read-only views sit beside the flag and enable registers. The first returns the index of the highest-numbered pending flag, or all ones when nothing is pending. The second shows which of the two groups has anything pending. Every source passes through a two-stage synchronizer before its edge detector. The register port has a 2-bit address, a write strobe, write data and read data, and reads are combinational from the address.

Top module: `evt_prio_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the flags and the enables read 0x00, the priority view reads 0xFF, the group view reads 0x00, and both request lines are low.
- R2: A 0-to-1 change on an enabled source sets its flag, and the flag becomes visible on the third rising clock edge after the change. Bit i of the flag register at offset 0 belongs to source i.
- R3: A rising edge on a source whose enable bit is 0 sets nothing. Setting the enable bit later while the source is already high also sets nothing.
- R4: A write to offset 0 clears every flag whose write-data bit is 1 and leaves flags whose write-data bit is 0 unchanged.
- R5: Offset 1 is the enable register. It reads back what was written, and bit i enables source i.
- R6: Offset 2 reads the index (0 to 7) of the highest-numbered set flag, or 0xFF when no flag is set.
- R7: Offset 3 reads the group view: bit 1 is set when any of flags 7..4 is set, bit 0 is set when any of flags 3..0 is set, and bits 7..2 read 0.
- R8: `evtHigh` is the OR of flags 7..4 and `evtLow` is the OR of flags 3..0.
- R9: When a new edge on an enabled source arrives at the same clock edge as a write-one clear of that flag, the flag stays set.
- R10: Writes to offsets 2 and 3 change no state. Read data follows the address in the same cycle.
- R11: A source that stays high sets its flag only once. After a clear, the flag stays clear until the next 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the source sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register offset (0 flags, 1 enable, 2 priority, 3 group) |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| evtSrc | input | 8 | Asynchronous event sources |
| evtHigh | output | 1 | Request line for the urgent group (sources 7..4) |
| evtLow | output | 1 | Request line for the routine group (sources 3..0) |

## Verification
A write-one clear of a flag can land on the same clock edge at which a new synchronized edge of that source is detected. The clear must then lose, so that no event goes missing. The bench provokes this on purpose. It raises a source exactly two cycles before it issues the clear, then expects the flag to read 1 afterwards. The random phase clears bits at arbitrary times while sources toggle, which hits the same collision again and again. A bench model that counts the three-cycle latency independently judges every cycle.

// File: rtl/evt_prio_pkg.sv
package evt_prio_pkg;

  parameter int NUM_SRC = 8;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 2;

  // register offsets; the bench relies on them
  parameter logic [ADDR_W-1:0] OFS_FLAG  = 2'd0;
  parameter logic [ADDR_W-1:0] OFS_EN    = 2'd1;
  parameter logic [ADDR_W-1:0] OFS_PRIO  = 2'd2;
  parameter logic [ADDR_W-1:0] OFS_LEVEL = 2'd3;

  typedef enum logic [1:0] {
    SEL_FLAG  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_PRIO  = 2'd2,
    SEL_LEVEL = 2'd3
  } rdSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   wrFlagClr;
    logic   wrEnable;
    rdSel_t rdSel;
  } evtStrobe_t;

endpackage

// File: rtl/evt_prio_sync.sv
module evt_prio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/evt_prio_decode.sv
module evt_prio_decode
  import evt_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output evtStrobe_t        strobe
);

  always_comb begin
    strobe.wrFlagClr = regWrEn && (regAddr == OFS_FLAG);
    strobe.wrEnable  = regWrEn && (regAddr == OFS_EN);
    unique case (regAddr)
      OFS_FLAG:  strobe.rdSel = SEL_FLAG;
      OFS_EN:    strobe.rdSel = SEL_EN;
      OFS_PRIO:  strobe.rdSel = SEL_PRIO;
      default:   strobe.rdSel = SEL_LEVEL;
    endcase
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrFlagClr, strobe.wrEnable})); // R10

  AST_RO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (strobe.rdSel == SEL_PRIO || strobe.rdSel == SEL_LEVEL))
      |-> !(strobe.wrFlagClr || strobe.wrEnable)); // R10

endmodule

// File: rtl/evt_prio_datapath.sv
module evt_prio_datapath
  import evt_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  evtStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [DATA_W-1:0]  rdData,
  output logic               evtHigh,
  output logic               evtLow
);

  localparam int HALF = NUM_SRC / 2;
  localparam logic [DATA_W-1:0] NONE_CODE = {DATA_W{1'b1}};

  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] clrMask;
  logic [DATA_W-1:0]  prioCode;
  logic [DATA_W-1:0]  levelBits;

  // edge detector on the synchronized sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= srcSync;
  end
  assign riseVec = srcSync & ~prevQ;

  // enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enQ <= '0;
    else if (strobe.wrEnable) enQ <= wrData[NUM_SRC-1:0];
  end

  // flags: a new edge wins over a write-one clear
  assign clrMask = strobe.wrFlagClr ? wrData[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | (riseVec & enQ);
  end

  // highest pending index, all ones when empty
  always_comb begin
    prioCode = NONE_CODE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (flagQ[i]) prioCode = DATA_W'(i);
    end
  end

  always_comb begin
    levelBits    = '0;
    levelBits[1] = |flagQ[NUM_SRC-1:HALF];
    levelBits[0] = |flagQ[HALF-1:0];
  end

  assign evtHigh = |flagQ[NUM_SRC-1:HALF];
  assign evtLow  = |flagQ[HALF-1:0];

  always_comb begin
    unique case (strobe.rdSel)
      SEL_FLAG:  rdData = DATA_W'(flagQ);
      SEL_EN:    rdData = DATA_W'(enQ);
      SEL_PRIO:  rdData = prioCode;
      default:   rdData = levelBits;
    endcase
  end

  AST_NO_UNENABLED_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(enQ)) == '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrFlagClr |=> ((flagQ & $past(wrData[NUM_SRC-1:0]) & ~$past(riseVec)) == '0)); // R4

  AST_EDGE_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseVec & enQ) & ~flagQ) == '0)); // R9

  AST_PRIO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ == '0) |-> (prioCode == NONE_CODE)); // R6

  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ != '0) |-> ((flagQ >> prioCode) == NUM_SRC'(1))); // R6

  AST_HIGH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    evtHigh |-> (prioCode >= DATA_W'(HALF) && prioCode != NONE_CODE)); // R8

  AST_LOW_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (evtLow && !evtHigh) |-> (prioCode < DATA_W'(HALF))); // R8

endmodule

// File: rtl/evt_prio_ctrl.sv
module evt_prio_ctrl
  import evt_prio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_SRC-1:0] evtSrc,
  output logic              evtHigh,
  output logic              evtLow
);

  evtStrobe_t         strobe;
  logic [NUM_SRC-1:0] srcSync;

  evt_prio_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (evtSrc),
    .syncOut (srcSync)
  );

  evt_prio_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  evt_prio_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .srcSync (srcSync),
    .rdData  (regRdData),
    .evtHigh (evtHigh),
    .evtLow  (evtLow)
  );

endmodule

// File: tb/evt_prio_ctrl_tb.sv
`timescale 1ns/1ps
module evt_prio_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [7:0] evtSrc = 8'd0;
  logic       evtHigh, evtLow;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  evt_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtSrc(evtSrc),
    .evtHigh(evtHigh), .evtLow(evtLow)
  );

  // reference model built from the requirements
  logic [7:0] mFlag, mEn, mS1, mS2, mS3;
  always @(posedge clk or negedge rstN) begin
    logic [7:0] rise, clr;
    if (!rstN) begin
      mFlag = 0; mEn = 0; mS1 = 0; mS2 = 0; mS3 = 0;
    end else begin
      rise  = mS2 & ~mS3;
      clr   = (regWrEn && regAddr == 2'd0) ? regWrData : 8'd0;
      mFlag = (mFlag & ~clr) | (rise & mEn);
      if (regWrEn && regAddr == 2'd1) mEn = regWrData;
      mS3 = mS2; mS2 = mS1; mS1 = evtSrc;
    end
  end

  function automatic logic [7:0] expPrio(input logic [7:0] f);
    expPrio = 8'hFF;
    for (int i = 7; i >= 0; i--) if (f[i] && expPrio == 8'hFF) expPrio = 8'(i);
  endfunction

  function automatic logic [7:0] expLevel(input logic [7:0] f);
    expLevel = {6'd0, |f[7:4], |f[3:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  // called just after a falling edge
  task automatic checkAll();
    logic [7:0] d;
    readReg(2'd0, d); check("R2 flags", d, mFlag);
    readReg(2'd1, d); check("R5 enable", d, mEn);
    readReg(2'd2, d); check("R6 priority", d, expPrio(mFlag));
    readReg(2'd3, d); check("R7 level", d, expLevel(mFlag));
    check("R8 lines", {6'd0, evtHigh, evtLow}, expLevel(mFlag));
  endtask

  // drive one cycle of stimulus, consume one rising edge, return after the falling edge
  task automatic cyc(input logic [7:0] s, input logic w, input logic [1:0] a, input logic [7:0] d);
    evtSrc = s; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    // R1: during reset
    readReg(2'd0, d); check("R1 flags in reset", d, 8'h00);
    readReg(2'd2, d); check("R1 prio in reset", d, 8'hFF);
    cyc(8'h00, 0, 0, 0);
    rstN = 1'b1;
    cyc(8'h00, 0, 0, 0);
    readReg(2'd0, d); check("R1 flags", d, 8'h00);
    readReg(2'd1, d); check("R1 enable", d, 8'h00);
    readReg(2'd2, d); check("R1 prio", d, 8'hFF);
    readReg(2'd3, d); check("R1 level", d, 8'h00);
    check("R1 lines", {6'd0, evtHigh, evtLow}, 8'h00);

    // R3: disabled edge, then late enable while high
    cyc(8'h20, 0, 0, 0);
    repeat (4) cyc(8'h20, 0, 0, 0);
    readReg(2'd0, d); check("R3 disabled edge", d, 8'h00);
    cyc(8'h20, 1, 2'd1, 8'h20);
    repeat (4) cyc(8'h20, 0, 0, 0);
    readReg(2'd0, d); check("R3 late enable", d, 8'h00);

    // R2: latency of an enabled edge
    cyc(8'h00, 1, 2'd1, 8'hFF);
    repeat (3) cyc(8'h00, 0, 0, 0);
    cyc(8'h04, 0, 0, 0);
    cyc(8'h04, 0, 0, 0);
    readReg(2'd0, d); check("R2 not before third edge", d, 8'h00);
    cyc(8'h04, 0, 0, 0);
    readReg(2'd0, d); check("R2 set on third edge", d, 8'h04);
    check("R8 low line", {6'd0, evtHigh, evtLow}, 8'h01);
    checkAll();

    // R6/R7: several flags
    cyc(8'h84, 0, 0, 0); cyc(8'h84, 0, 0, 0); cyc(8'h84, 0, 0, 0);
    readReg(2'd2, d); check("R6 highest index", d, 8'h07);
    readReg(2'd3, d); check("R7 both groups", d, 8'h03);

    // R4: write zero, then partial clear
    cyc(8'h84, 1, 2'd0, 8'h00);
    readReg(2'd0, d); check("R4 write zero keeps", d, 8'h84);
    cyc(8'h84, 1, 2'd0, 8'hF0);
    readReg(2'd0, d); check("R4 clear upper", d, 8'h04);
    readReg(2'd2, d); check("R6 after clear", d, 8'h02);

    // R10: writes to read-only offsets
    cyc(8'h84, 1, 2'd2, 8'h00);
    cyc(8'h84, 1, 2'd3, 8'hFF);
    readReg(2'd0, d); check("R10 flags untouched", d, 8'h04);
    readReg(2'd1, d); check("R10 enable untouched", d, 8'hFF);
    readReg(2'd2, d); check("R10 prio untouched", d, 8'h02);

    // R9: edge and clear on the same clock edge
    cyc(8'h00, 0, 0, 0); cyc(8'h00, 0, 0, 0); cyc(8'h00, 0, 0, 0);
    cyc(8'h01, 1, 2'd0, 8'hFF);  // clears old flags; edge k
    cyc(8'h01, 0, 0, 0);         // edge k+1
    cyc(8'h01, 1, 2'd0, 8'h01);  // edge k+2: rise and clear collide
    readReg(2'd0, d); check("R9 edge beats clear", d, 8'h01);

    // R11: steady high source does not re-arm
    cyc(8'h01, 1, 2'd0, 8'h01);
    repeat (5) cyc(8'h01, 0, 0, 0);
    readReg(2'd0, d); check("R11 steady high", d, 8'h00);
    checkAll();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] s, wd;
      logic w;
      logic [1:0] a;
      s  = 8'($urandom());
      w  = ($urandom() % 4) == 0;
      a  = 2'($urandom());
      wd = 8'($urandom());
      if (a == 2'd1 && ($urandom() % 2) == 0) wd = wd | 8'hC3;
      cyc(s, w, a, wd);
      checkAll();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule